// File: doc/BRIEF.md
# Serial Clock Synthesizer Programming Controller

This block sits on the host side of a serially configured clock synthesizer. When `start` is pulsed it takes six configuration fields: a 7-bit reference divider, a 9-bit feedback (VCO) divider, a 3-bit output divider code, a 2-bit code for the secondary output's function, a duty-cycle trim bit and a 2-bit crystal load code. It checks both divider words first. If either is illegal, the request is refused and nothing is sent on the serial pins. If both are legal, the fields are packed into a 24-bit word and shifted out on a three-wire link.

The shift sends one bit per serial clock rising edge while the commit line stays low. After a settling gap the controller raises the commit line for a fixed width. It then waits a programmable lock interval and reports `done`. Every timing minimum is a parameter counted in system clock cycles, each rounded up from its nanosecond or millisecond figure: data setup, serial-clock high time (hold), the gap before commit, the commit pulse width, and the lock wait.

The controller is a single state machine with these states:

- `ST_IDLE`: waiting for a request.
- `ST_SETUP`: serial clock low, data bit presented.
- `ST_HIGH`: serial clock high, data held.
- `ST_GAP`: wait after the last serial clock edge.
- `ST_STROBE`: commit pulse.
- `ST_LOCK`: lock wait.
- `ST_DONE`: one-cycle completion.
- `ST_FAULT`: one-cycle rejection.

Its transitions are:

- IDLE to SETUP on a legal start.
- IDLE to FAULT on an illegal start.
- SETUP to HIGH when the setup count expires.
- HIGH back to SETUP while bits remain.
- HIGH to GAP after the last bit.
- GAP to STROBE.
- STROBE to LOCK.
- LOCK to DONE.
- DONE or FAULT back to IDLE.

Top module: `clkprog_master`

## Requirements
- R1: An accepted request transmits the 24-bit word MSB first, with this layout: bits 23:22 load code, bit 21 duty bit, bits 20:19 secondary-function code, bits 18:16 output-divider code, bits 15:7 feedback divider, bits 6:0 reference divider.
- R2: `ser_data` is sampled by the target on each `ser_clk` rising edge. It is stable for at least SETUP_CYC cycles before that edge. `ser_clk` then stays high for at least HOLD_CYC cycles, and `ser_data` does not change while it is high.
- R3: An accepted request produces exactly 24 rising edges on `ser_clk`.
- R4: `ser_strobe` stays low while any bit is being shifted. It rises no sooner than WAIT_CYC cycles after the last falling edge of `ser_clk`.
- R5: `ser_strobe` is high for exactly STB_CYC cycles per accepted request.
- R6: `done` is high for exactly one cycle, LOCK_CYC cycles after `ser_strobe` falls. `ser_strobe` and `ser_clk` are low at that time.
- R7: A request with feedback divider below 4 or reference divider equal to 0 raises `error` for one cycle, in the cycle after `start` is sampled. It produces no `ser_clk` edge and no `ser_strobe` pulse.
- R8: `busy` is high from the cycle after an accepted `start` through the `done` or `error` cycle. A `start` seen while `busy` is high is ignored: the transmitted word is unchanged and only one `done` follows.
- R9: After reset, and whenever `busy` is low, `ser_clk`, `ser_data` and `ser_strobe` are low. After reset `done` and `error` are also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request pulse, sampled in idle only |
| ref_div | input | 7 | Reference divider word |
| vco_div | input | 9 | Feedback divider word |
| out_div | input | 3 | Output divider code |
| aux_fn | input | 2 | Secondary output function code |
| duty_sel | input | 1 | Duty-cycle trim bit |
| load_cap | input | 2 | Crystal load code |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_strobe | output | 1 | Commit line to the synthesizer |

## Verification
The assertions check several rules on every cycle:

- Data never moves while the serial clock is high.
- The commit line is never high during shifting.
- The serial pins rest low whenever the block is idle.
- `done` and `error` are single-cycle pulses that coincide with the end of `busy`.

Other behaviour can only be shown by the bench's scenarios, which decode the serial stream and measure intervals between pin edges:

- The word content and its bit order.
- The exact count of 24 edges.
- The setup and gap intervals.
- The commit pulse width and the lock delay.
- The fact that a start issued mid-transfer leaves the word unchanged.

// File: rtl/clkprog_pkg.sv
package clkprog_pkg;

    localparam int FRAME_W   = 24;
    localparam int BITIDX_W  = $clog2(FRAME_W);
    localparam int VCO_MIN   = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_GAP,
        ST_STROBE,
        ST_LOCK,
        ST_DONE,
        ST_FAULT
    } state_e;

    // Packed MSB first: first field is transmitted first
    typedef struct packed {
        logic [1:0] load_cap;
        logic       duty_sel;
        logic [1:0] aux_fn;
        logic [2:0] out_div;
        logic [8:0] vco_div;
        logic [6:0] ref_div;
    } frame_t;

endpackage

// File: rtl/clkprog_frame.sv
module clkprog_frame
    import clkprog_pkg::*;
(
    input  logic [6:0] ref_div,
    input  logic [8:0] vco_div,
    input  logic [2:0] out_div,
    input  logic [1:0] aux_fn,
    input  logic       duty_sel,
    input  logic [1:0] load_cap,
    output frame_t     word,
    output logic       legal
);

    always_comb begin
        word.load_cap = load_cap;
        word.duty_sel = duty_sel;
        word.aux_fn   = aux_fn;
        word.out_div  = out_div;
        word.vco_div  = vco_div;
        word.ref_div  = ref_div;
        legal = (vco_div >= 9'(VCO_MIN)) && (ref_div != 7'd0);
    end

endmodule

// File: rtl/clkprog_timer.sv
module clkprog_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/clkprog_master.sv
module clkprog_master
    import clkprog_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2,
    parameter int WAIT_CYC  = 2,
    parameter int STB_CYC   = 5,
    parameter int LOCK_CYC  = 1250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [6:0] ref_div,
    input  logic [8:0] vco_div,
    input  logic [2:0] out_div,
    input  logic [1:0] aux_fn,
    input  logic       duty_sel,
    input  logic [1:0] load_cap,
    output logic       busy,
    output logic       done,
    output logic       error,
    output logic       ser_clk,
    output logic       ser_data,
    output logic       ser_strobe
);

    localparam int MAX_A  = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAX_B  = (WAIT_CYC > STB_CYC) ? WAIT_CYC : STB_CYC;
    localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_D  = (MAX_C > LOCK_CYC) ? MAX_C : LOCK_CYC;
    localparam int TW     = $clog2(MAX_D + 1);

    state_e              state_q, state_d;
    logic [BITIDX_W-1:0] bit_q, bit_d;
    frame_t              word_q, word_d, word_in;
    logic                legal;
    logic                frame_ld;
    logic                tmr_load;
    logic [TW-1:0]       tmr_val;
    logic                tmr_exp;

    clkprog_frame u_frame (
        .ref_div  (ref_div),
        .vco_div  (vco_div),
        .out_div  (out_div),
        .aux_fn   (aux_fn),
        .duty_sel (duty_sel),
        .load_cap (load_cap),
        .word     (word_in),
        .legal    (legal)
    );

    clkprog_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        bit_d    = bit_q;
        frame_ld = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    frame_ld = 1'b1;
                    if (legal) begin
                        state_d  = ST_SETUP;
                        bit_d    = BITIDX_W'(FRAME_W - 1);
                        tmr_load = 1'b1;
                        tmr_val  = TW'(SETUP_CYC - 1);
                    end else begin
                        state_d  = ST_FAULT;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_exp) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(HOLD_CYC - 1);
                end
            end
            ST_HIGH: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    if (bit_q == '0) begin
                        state_d = ST_GAP;
                        tmr_val = TW'(WAIT_CYC - 1);
                    end else begin
                        state_d = ST_SETUP;
                        bit_d   = bit_q - 1'b1;
                        tmr_val = TW'(SETUP_CYC - 1);
                    end
                end
            end
            ST_GAP: begin
                if (tmr_exp) begin
                    state_d  = ST_STROBE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(STB_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_exp) begin
                    state_d  = ST_LOCK;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(LOCK_CYC - 1);
                end
            end
            ST_LOCK: begin
                if (tmr_exp)
                    state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign word_d = frame_ld ? word_in : word_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            word_q  <= word_d;
        end
    end

    // Registered outputs decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            done       <= 1'b0;
            error      <= 1'b0;
            ser_clk    <= 1'b0;
            ser_data   <= 1'b0;
            ser_strobe <= 1'b0;
        end else begin
            busy       <= (state_d != ST_IDLE);
            done       <= (state_d == ST_DONE);
            error      <= (state_d == ST_FAULT);
            ser_clk    <= (state_d == ST_HIGH);
            ser_data   <= ((state_d == ST_SETUP) || (state_d == ST_HIGH))
                          ? word_d[bit_d] : 1'b0;
            ser_strobe <= (state_d == ST_STROBE);
        end
    end

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R4
    strobe_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SETUP) || (state_q == ST_HIGH)) |-> !ser_strobe);

    // R6
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ser_strobe && !ser_clk));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!ser_clk && !ser_strobe && !done));

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || error));

    // R9
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ser_clk && !ser_data && !ser_strobe));

endmodule

// File: tb/clkprog_master_tb.sv
module clkprog_master_tb_top;

    localparam int SETUP = 2;
    localparam int HOLD  = 2;
    localparam int WAITC = 2;
    localparam int STB   = 5;
    localparam int LOCK  = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [6:0] ref_div = '0;
    logic [8:0] vco_div = '0;
    logic [2:0] out_div = '0;
    logic [1:0] aux_fn = '0;
    logic       duty_sel = 1'b0;
    logic [1:0] load_cap = '0;
    logic       busy, done, error, ser_clk, ser_data, ser_strobe;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    clkprog_master #(
        .SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .WAIT_CYC(WAITC),
        .STB_CYC(STB), .LOCK_CYC(LOCK)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ref_div(ref_div), .vco_div(vco_div), .out_div(out_div),
        .aux_fn(aux_fn), .duty_sel(duty_sel), .load_cap(load_cap),
        .busy(busy), .done(done), .error(error),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_strobe(ser_strobe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_word(input logic [6:0] r, input logic [8:0] v,
            input logic [2:0] o, input logic [1:0] f, input logic d, input logic [1:0] c);
        return {c, d, f, o, v, r};
    endfunction

    // Pin monitor
    int          cyc = 0;
    int          nbits = 0;
    logic [23:0] cap = '0;
    int          dstab = 0;
    int          hi_cnt = 0;
    logic        hi_data = 1'b0;
    bit          hold_bad = 1'b0;
    int          last_fall = 0;
    int          stb_cnt = 0;
    int          stb_fall = 0;
    int          stb_seen = 0;
    int          done_seen = 0;
    logic        p_clk = 1'b0, p_data = 1'b0, p_stb = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (ser_data != p_data) dstab = 1; else dstab++;
            if (ser_clk && !p_clk) begin
                chk(dstab - 1 >= SETUP, "R2 setup cycles", dstab - 1, SETUP);
                cap = {cap[22:0], ser_data};
                nbits++;
                hi_cnt = 1;
                hi_data = ser_data;
                hold_bad = 1'b0;
            end else if (ser_clk) begin
                hi_cnt++;
                if (ser_data != hi_data) hold_bad = 1'b1;
            end
            if (!ser_clk && p_clk) begin
                chk(hi_cnt >= HOLD, "R2 clock high cycles", hi_cnt, HOLD);
                chk(!hold_bad, "R2 data held while high", int'(hold_bad), 0);
                last_fall = cyc;
            end
            if (ser_strobe && !p_stb) begin
                chk(nbits == 24, "R4 strobe after all bits", nbits, 24);
                chk(cyc - last_fall >= WAITC, "R4 gap before strobe", cyc - last_fall, WAITC);
                stb_cnt = 0;
                stb_seen++;
            end
            if (ser_strobe) begin
                stb_cnt++;
                chk(!ser_clk, "R4 no clock during strobe", int'(ser_clk), 0);
            end
            if (!ser_strobe && p_stb) begin
                chk(stb_cnt == STB, "R5 strobe width", stb_cnt, STB);
                stb_fall = cyc;
            end
            if (done) begin
                done_seen++;
                chk(cyc - stb_fall == LOCK, "R6 lock delay", cyc - stb_fall, LOCK);
            end
        end
        p_clk = ser_clk;
        p_data = ser_data;
        p_stb = ser_strobe;
    end

    task automatic send(input logic [6:0] r, input logic [8:0] v, input logic [2:0] o,
                        input logic [1:0] f, input logic d, input logic [1:0] c, input bit poke);
        bit legal;
        int n;
        legal = (v >= 9'd4) && (r != 7'd0);
        @(negedge clk);
        #1;
        nbits = 0; cap = '0; stb_seen = 0; done_seen = 0;
        ref_div = r; vco_div = v; out_div = o; aux_fn = f; duty_sel = d; load_cap = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        if (!legal) begin
            chk(error == 1'b1, "R7 error pulse", int'(error), 1);
            chk(busy == 1'b1, "R8 busy on reject", int'(busy), 1);
            @(negedge clk);
            #1;
            chk(error == 1'b0, "R7 error one cycle", int'(error), 0);
            repeat (5) @(negedge clk);
            #1;
            chk(nbits == 0, "R7 no clock edges", nbits, 0);
            chk(stb_seen == 0, "R7 no strobe", stb_seen, 0);
            chk(busy == 1'b0, "R9 idle after reject", int'(busy), 0);
            return;
        end
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        chk(error == 1'b0, "R7 no error on legal", int'(error), 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            ref_div = ~r; vco_div = ~v; out_div = ~o; aux_fn = ~f; duty_sel = ~d; load_cap = ~c;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(n < 5000, "R6 watchdog", n, 5000);
        chk(nbits == 24, "R3 edge count", nbits, 24);
        chk(cap == exp_word(r, v, o, f, d, c), poke ? "R8 word kept under busy start" : "R1 word",
            int'(cap), int'(exp_word(r, v, o, f, d, c)));
        chk(stb_seen == 1, "R5 one strobe", stb_seen, 1);
        chk(busy == 1'b1, "R8 busy during done", int'(busy), 1);
        @(negedge clk);
        #1;
        chk(done == 1'b0, "R6 done one cycle", int'(done), 0);
        chk(busy == 1'b0, "R8 busy released", int'(busy), 0);
        repeat (10) @(negedge clk);
        #1;
        chk(done_seen == 1, "R8 single done", done_seen, 1);
        chk(!ser_clk && !ser_data && !ser_strobe, "R9 idle pins", int'({ser_clk, ser_data, ser_strobe}), 0);
    endtask

    initial begin
        void'($urandom(32'd307));
        repeat (3) @(negedge clk);
        chk({busy, done, error, ser_clk, ser_data, ser_strobe} == 6'b0, "R9 reset state",
            int'({busy, done, error, ser_clk, ser_data, ser_strobe}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, done, error, ser_clk, ser_data, ser_strobe} == 6'b0, "R9 after reset",
            int'({busy, done, error, ser_clk, ser_data, ser_strobe}), 0);

        send(7'd59, 9'd276, 3'd1, 2'd2, 1'b0, 2'd0, 1'b0);     // R1 directed
        send(7'd1, 9'd4, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0);        // R7 lowest legal
        send(7'd127, 9'd511, 3'd7, 2'd3, 1'b1, 2'd3, 1'b0);    // R1 all-ones
        send(7'd10, 9'd3, 3'd2, 2'd1, 1'b1, 2'd1, 1'b0);       // R7 vco too small
        send(7'd0, 9'd100, 3'd2, 2'd1, 1'b1, 2'd1, 1'b0);      // R7 ref zero
        send(7'd0, 9'd0, 3'd0, 2'd0, 1'b0, 2'd0, 1'b0);        // R7 both bad
        send(7'h55, 9'h0AA, 3'd5, 2'd1, 1'b0, 2'd2, 1'b1);     // R8 start while busy

        for (int i = 0; i < 40; i++) begin
            logic [6:0] r;
            logic [8:0] v;
            r = 7'($urandom);
            v = 9'($urandom);
            if ((i % 8) != 7) begin
                if (r == 7'd0) r = 7'd1;
                if (v < 9'd4) v = 9'd4 + v;
            end
            send(r, v, 3'($urandom), 2'($urandom), 1'($urandom), 2'($urandom), (i % 10) == 5);
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule